// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing engine of a two-wire serial EEPROM slave. It oversamples the (already filtered) clock and data lines on a fast system clock, recognises start and stop conditions, and decodes the device address word. The device address word carries a fixed four-bit device code, the three most significant memory address bits and a read/write flag. The engine takes the low memory address byte and carries out byte writes, page writes, current-address reads, random reads and sequential reads. It pulls the data line low through an open-drain enable.

The engine owns the 11-bit address counter. Toward the write controller it issues one strobe per received data byte, carrying the address and the data. It also issues a single commit pulse when a stop follows written data. Read data comes in through a port that is addressed by the counter. While the write controller reports busy, every device address word is refused, so the host can poll for the end of the internal write cycle.

Top module: `ee2w_slave`

## Requirements
- R1: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high. Bits are taken on the rising clock edge. The engine changes its data-line drive only after a falling clock edge, never while the clock is high.
- R2: A device address word is sent MSB first: bits 7..4 are the device code, bits 3..1 are memory address bits 10..8, and bit 0 is the read/write flag (1 = read). If bits 7..4 equal 1010 and the engine is not busy, it pulls the data line low in the 9th clock. Otherwise it gives no acknowledge and ignores the bus until the next start.
- R3: While busy_i is high, a device address word gets no acknowledge. Once busy_i is low, the same word is acknowledged.
- R4: In a write, the byte after the device address word sets address bits 7..0. Bits 10..8 come from the device address word. That byte and each following data byte are acknowledged. Each data byte produces a one-cycle wr_en with wr_addr and wr_data.
- R5: After each written byte, address bits 3..0 increment and wrap within the 16-byte page, while bits 10..4 stay unchanged. The counter on rd_addr follows the same rule.
- R6: A stop that follows at least one written data byte produces a single one-cycle commit pulse. A stop after a read, after a refused word, or after a write that carried no data byte produces none.
- R7: A read sends the byte at the counter address, MSB first. If the host acknowledges, the next byte follows. If the host does not acknowledge, the engine releases the data line and goes idle.
- R8: Every byte sent in a read advances the counter by one over the whole 11-bit range, wrapping from 7FFh to 000h. After a read, rd_addr holds the last byte's address plus one.
- R9: A write-mode address phase, followed by a repeated start and a read-mode word, returns data starting at the address set in that address phase.
- R10: Reset clears the counter to 000h and releases the data line.
- R11: A repeated start at any point ends the current transaction and returns the engine to device address word reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Filtered serial clock line |
| sda_i | input | 1 | Filtered serial data line (bus level) |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe | output | 1 | 1 = pull the data line low |
| wr_en | output | 1 | One-cycle strobe per received data byte |
| wr_addr | output | 11 | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| rd_addr | output | 11 | Address counter, read address for the array |
| rd_data | input | 8 | Array data at rd_addr |
| commit | output | 1 | One-cycle pulse on a stop after written data |

## Verification
A wrong address counter shows on rd_addr as soon as a byte completes. It also shows in the very next byte read out or strobed, so a single transfer of a few bytes exposes page-wrap and full-wrap mistakes. A bit counter that is off by one moves the acknowledge out of the 9th clock, and the host sees this within one byte. A state that fails to return to idle on a stop or a repeated start leaves the data line driven or gives a wrong acknowledge on the next device address word. A missing or doubled commit appears at the stop that ends the transfer.

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
  parameter int AW = 11,
  parameter int PW = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          busy_i,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          commit
);
  localparam int HW = AW - 8;
  localparam logic [AW-1:0] ONE = 1;
  localparam logic [PW-1:0] PONE = 1;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADR, ST_WR, ST_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic rw, mack, wrote;
  logic [HW-1:0] hi;
  logic [AW-1:0] addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  wire scl      = scl_sy[1];
  wire sda      = sda_sy[1];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire [AW-1:0] page_next = {addr[AW-1:PW], addr[PW-1:0] + PONE};

  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; rw <= 1'b0; mack <= 1'b1; wrote <= 1'b0;
      hi <= '0; addr <= '0; sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0;
      wr_data <= '0; commit <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      commit <= 1'b0;
      if (start_c) begin
        st <= ST_DEV; cnt <= '0; sda_oe <= 1'b0; wrote <= 1'b0;
      end else if (stop_c) begin
        commit <= (st == ST_WR) && wrote;
        st <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0; wrote <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            if (st != ST_RD) sr <= {sr[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            cnt <= 4'd9;
            if (st == ST_RD) begin
              mack <= sda;
              addr <= addr + ONE;
            end
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (st)
              ST_DEV:
                if (sr[7:4] == DEV_CODE && !busy_i) begin
                  sda_oe <= 1'b1; rw <= sr[0]; hi <= sr[HW:1];
                end else begin
                  st <= ST_IDLE; cnt <= '0;
                end
              ST_ADR: begin
                sda_oe <= 1'b1;
                addr <= {hi, sr};
              end
              ST_WR: begin
                sda_oe <= 1'b1; wr_en <= 1'b1; wr_addr <= addr; wr_data <= sr;
                addr <= page_next; wrote <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            sda_oe <= 1'b0;
            cnt <= '0;
            case (st)
              ST_DEV:
                if (rw) begin
                  st <= ST_RD; sr <= rd_data; sda_oe <= ~rd_data[7];
                end else st <= ST_ADR;
              ST_ADR: st <= ST_WR;
              ST_RD:
                if (!mack) begin
                  sr <= rd_data; sda_oe <= ~rd_data[7];
                end else st <= ST_IDLE;
              default: st <= st;
            endcase
          end else if (st == ST_RD && cnt != 4'd0) begin
            sr <= {sr[6:0], 1'b0};
            sda_oe <= ~sr[6];
          end
        end
      end
    end
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk #(
  parameter int AW = 11,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          commit
);
  localparam logic [PW-1:0] PONE = 1;
  logic [1:0] c_scl, c_sda;
  logic c_scl_d, c_sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_scl <= 2'b11; c_sda <= 2'b11; c_scl_d <= 1'b1; c_sda_d <= 1'b1;
    end else begin
      c_scl <= {c_scl[0], scl_i};
      c_sda <= {c_sda[0], sda_i};
      c_scl_d <= c_scl[1];
      c_sda_d <= c_sda[1];
    end

  wire k_start = c_scl[1] & c_scl_d & c_sda_d & ~c_sda[1];
  wire k_stop  = c_scl[1] & c_scl_d & ~c_sda_d & c_sda[1];

  a_r1_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    k_start |=> !sda_oe);
  a_r1_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !c_scl[1]);
  a_r5_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rd_addr == {wr_addr[AW-1:PW], wr_addr[PW-1:0] + PONE});
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(k_stop));
  a_r6_commit_not_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wr_en);
endmodule

bind ee2w_slave ee2w_slave_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .commit(commit)
);

// File: tb/ee2w_slave_test.sv
`timescale 1ns/1ps
module ee2w_slave_test;
  localparam int Q = 16;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, busy = 1'b0;
  logic sda_oe, wr_en, commit, sda_bus, done = 1'b0;
  logic [10:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [0:2047];
  int n_chk = 0, n_fail = 0, n_wr = 0, n_commit = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);
  assign rd_data = mem[rd_addr];

  ee2w_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .busy_i(busy),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .commit(commit)
  );

  always @(posedge clk) begin
    if (wr_en) begin mem[wr_addr] <= wr_data; n_wr <= n_wr + 1; end
    if (commit) n_commit <= n_commit + 1;
  end

  function automatic logic [7:0] pat(input int a);
    return a[7:0] ^ 8'h5A ^ {5'd0, a[10:8]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q/4);
    end
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q/2); ack = ~sda_bus; tick(Q/2);
    scl = 1'b0; tick(Q/4);
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q/2); d[i] = sda_bus; tick(Q/2); scl = 1'b0;
    end
    tick(Q/4); m_low = ack_it; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    tick(Q/4); m_low = 1'b0;
  endtask

  task automatic t_reset;
    logic a; logic [7:0] d;
    chk("R10 sda_oe after reset", sda_oe, 0);
    chk("R10 counter after reset", rd_addr, 0);
    chk("R6 no commit after reset", commit, 0);
    bus_start; send_byte(8'hA1, a);
    chk("R1 R2 start and code 1010 acknowledged", a, 1);
    recv_byte(1'b0, d); bus_stop;
    chk("R7 R10 current read at 000", d, pat(0));
    chk("R8 counter after one read byte", rd_addr, 1);
  endtask

  task automatic t_bad_code;
    logic a; int w = n_wr, c = n_commit;
    bus_start; send_byte(8'hB4, a);
    chk("R2 wrong code not acknowledged", a, 0);
    send_byte(8'h00, a);
    chk("R2 bus ignored after mismatch", a, 0);
    bus_stop;
    chk("R2 no strobe after mismatch", n_wr, w);
    chk("R6 no commit after mismatch", n_commit, c);
    chk("R1 data line released", sda_oe, 0);
  endtask

  task automatic t_byte_write;
    logic a; int c = n_commit, w = n_wr;
    bus_start; send_byte(8'hA6, a); chk("R4 write word ack", a, 1);
    send_byte(8'hA5, a); chk("R4 address byte ack", a, 1);
    send_byte(8'h96, a); chk("R4 data byte ack", a, 1);
    bus_stop;
    chk("R4 byte stored at 3A5", mem[11'h3A5], 8'h96);
    chk("R4 one strobe", n_wr, w + 1);
    chk("R6 one commit after write", n_commit, c + 1);
    chk("R5 counter after byte write", rd_addr, 11'h3A6);
  endtask

  task automatic t_page_write;
    logic a; int c = n_commit;
    bus_start; send_byte(8'hA2, a); send_byte(8'h2E, a);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'hC1 + 8'(i), a);
      chk("R4 page data ack", a, 1);
    end
    bus_stop;
    chk("R5 page 12E", mem[11'h12E], 8'hC1);
    chk("R5 page 12F", mem[11'h12F], 8'hC2);
    chk("R5 page wrap to 120", mem[11'h120], 8'hC3);
    chk("R5 page wrap to 121", mem[11'h121], 8'hC4);
    chk("R5 no spill into 130", mem[11'h130], pat(11'h130));
    chk("R5 counter after page write", rd_addr, 11'h122);
    chk("R6 single commit for page", n_commit, c + 1);
  endtask

  task automatic t_busy;
    logic a; int c = n_commit;
    busy = 1'b1;
    bus_start; send_byte(8'hA0, a);
    chk("R3 no ack while busy", a, 0);
    bus_stop;
    chk("R6 no commit after refused word", n_commit, c);
    busy = 1'b0;
    bus_start; send_byte(8'hA0, a);
    chk("R3 ack once idle", a, 1);
    bus_stop;
    chk("R6 no commit without data", n_commit, c);
  endtask

  task automatic t_random;
    logic a; logic [7:0] d; int c = n_commit;
    bus_start; send_byte(8'hA2, a); send_byte(8'h2E, a);
    bus_start; send_byte(8'hA1, a);
    chk("R9 read word after repeated start", a, 1);
    recv_byte(1'b1, d); chk("R9 random read 12E", d, 8'hC1);
    recv_byte(1'b1, d); chk("R7 sequential 12F", d, 8'hC2);
    recv_byte(1'b0, d); chk("R8 sequential crosses page to 130", d, pat(11'h130));
    bus_stop;
    chk("R8 counter after read", rd_addr, 11'h131);
    chk("R6 no commit after dummy write and read", n_commit, c);
    chk("R7 released after host nack", sda_oe, 0);
  endtask

  task automatic t_current;
    logic a; logic [7:0] d;
    bus_start; send_byte(8'hAF, a); recv_byte(1'b0, d); bus_stop;
    chk("R7 current read at 131", d, pat(11'h131));
    chk("R8 counter 132", rd_addr, 11'h132);
  endtask

  task automatic t_wrap;
    logic a; logic [7:0] d;
    bus_start; send_byte(8'hAE, a); send_byte(8'hFF, a);
    bus_start; send_byte(8'hA1, a);
    recv_byte(1'b1, d); chk("R9 random read 7FF", d, pat(11'h7FF));
    recv_byte(1'b0, d); chk("R8 read wraps to 000", d, pat(0));
    bus_stop;
    chk("R8 counter after wrap", rd_addr, 1);
  endtask

  task automatic t_abort;
    logic a; logic [7:0] d; int c = n_commit;
    bus_start; send_byte(8'hA0, a); send_byte(8'h40, a); send_byte(8'h11, a);
    bus_start; send_byte(8'hA1, a);
    chk("R11 word accepted after repeated start", a, 1);
    recv_byte(1'b0, d);
    chk("R11 read continues from 041", d, pat(11'h041));
    bus_stop;
    chk("R11 no commit after aborted write", n_commit, c);
    chk("R4 strobed byte at 040", mem[11'h040], 8'h11);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = pat(i);
    tick(10); rst_n = 1'b1; tick(10);
    t_reset;
    t_bad_code;
    t_byte_write;
    t_page_write;
    t_busy;
    t_random;
    t_current;
    t_wrap;
    t_abort;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule